// File: doc/BRIEF.md
# I2C Bridge Request Decoder

This block sits between a host byte channel and the I2C master engines of a bridge chip. Bytes of one request frame arrive one per cycle (with gaps allowed), the last byte marked by an end flag. As each byte arrives it is stored against its position in the frame. When the frame closes, the block checks the subsystem id, the opcode, the frame length, the bus index and the opcode-specific fields. It then reports a response header: subsystem id, echoed opcode and a status code. Accepted presence-probe, transfer and scan requests also raise a one-cycle command strobe that carries the decoded parameters to the engines.

The block also holds one bus clock-rate register per bus. A frequency-set request writes it and a frequency-read request returns it. Multi-byte fields are little-endian: the two 16-bit transfer lengths and the 32-bit frequency.

Frame layouts by byte position are as follows. Position 0 is the subsystem id and position 1 is the opcode; both are common to all frames. Probe (opcode 0x00) adds bus at 2 and address at 3. Transfer (0x01) adds bus at 2, address at 3 and flags at 4, then the write length at 5–6 and the read length at 7–8, followed by write data. Scan (0x02) and frequency-read (0x04) add bus at 2. Frequency-set (0x03) adds bus at 2 and the frequency at 3–6.

Top module: `bridge_cmd_decoder`

## Requirements
- R1: Two clock edges after the edge that samples the last byte of a frame, `rspValid` is high for one cycle. At that point `rspSub` is 0x01, `rspOp` echoes byte 1 of the frame (0 if the frame had only one byte), and `rspStatus` is one of 0 (ok), 2 (invalid), 4 (no such bus) or 7 (bad size).
- R2: A frame whose byte 0 is not 0x01 gets status 2 and no command strobe.
- R3: An opcode from 0x05 to 0xFF gets status 2 and no command strobe.
- R4: A frame that ends before all the fixed fields of its opcode have arrived gets status 7. The fixed lengths are 4 bytes for probe, 9 for transfer, 7 for frequency-set and 3 for scan and frequency-read. A frame of a single byte also counts as short.
- R5: A bus index of 2 or more gets status 4.
- R6: For probe and transfer, an address byte with bit 7 set gets status 2. For transfer, flags bits 7:1 not all zero also give status 2. If neither applies, a write or read length above 2048 gives status 7; 2048 itself is accepted.
- R7: An accepted probe, transfer or scan raises `cmdValid` in the same cycle as `rspValid`. It carries the opcode, the bus, the 7-bit address and the no-stop flag (flags bit 0), plus both lengths. Fields that the opcode does not carry read as zero.
- R8: Frequency-set parses the 32-bit little-endian frequency. It accepts only 100000, 400000 and 1000000, storing the value with status 0. Any other value gives status 2 and leaves the register unchanged.
- R9: An accepted frequency-read returns the selected bus register on `rspFreq`. Every other response shows `rspFreq` as 0.
- R10: After reset, both bus frequency registers hold 100000.
- R11: Bytes beyond the fixed fields (write data) do not change the decoded fields or the status.
- R12: The checks run in this order, and the first failing one sets the status: subsystem id, opcode present, opcode defined, length, bus index, then opcode fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A frame byte is present |
| inData | input | 8 | Frame byte |
| inLast | input | 1 | Byte is the last of its frame |
| cmdValid | output | 1 | One-cycle command strobe |
| cmdOp | output | 8 | Command opcode |
| cmdBus | output | 8 | Command bus index |
| cmdAddr | output | 7 | Target address |
| cmdNoStop | output | 1 | Suppress closing stop |
| cmdTxLen | output | 16 | Write length |
| cmdRxLen | output | 16 | Read length |
| rspValid | output | 1 | Response header valid |
| rspSub | output | 8 | Subsystem id of the response |
| rspOp | output | 8 | Echoed opcode |
| rspStatus | output | 8 | Status code |
| rspFreq | output | 32 | Frequency read back |

## Verification
The assertions check on every cycle that each response is produced by a frame end two cycles earlier and that each status is a legal code. They also check that a command strobe appears only with an ok response, that transfer lengths stay within the limit, that unused command fields are zero, and that reserved opcodes always get status 2. Only the bench's scenarios can show the parsing itself. That covers little-endian assembly, the exact boundary at 2048, the order in which the checks take priority, the fact that a rejected frequency leaves the register untouched, and the values read back after reset and after writes.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  localparam int IDX_W = 4;

  localparam logic [7:0] OP_PROBE = 8'h00;
  localparam logic [7:0] OP_XFER  = 8'h01;
  localparam logic [7:0] OP_SCAN  = 8'h02;
  localparam logic [7:0] OP_SETF  = 8'h03;
  localparam logic [7:0] OP_GETF  = 8'h04;

  localparam logic [7:0] ST_OK    = 8'd0;
  localparam logic [7:0] ST_INVAL = 8'd2;
  localparam logic [7:0] ST_NOBUS = 8'd4;
  localparam logic [7:0] ST_SIZE  = 8'd7;

  typedef struct packed {
    logic             load;
    logic [IDX_W-1:0] idx;
    logic             close;
    logic             eval;
  } ctrlStrobe_t;

  function automatic logic [IDX_W-1:0] fixedLen(input logic [7:0] op);
    case (op)
      OP_PROBE: return IDX_W'(4);
      OP_XFER:  return IDX_W'(9);
      OP_SETF:  return IDX_W'(7);
      default:  return IDX_W'(3);
    endcase
  endfunction
endpackage

// File: rtl/bridge_ctrl.sv
module bridge_ctrl
  import bridge_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inLast,
  output ctrlStrobe_t strb
);
  logic [IDX_W-1:0] byteCnt;
  logic             pending;

  always_comb begin
    strb.load  = inValid;
    strb.idx   = byteCnt;
    strb.close = inValid && inLast;
    strb.eval  = pending;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt <= '0;
      pending <= 1'b0;
    end else begin
      pending <= inValid && inLast;
      if (inValid) begin
        if (inLast) byteCnt <= '0;
        else if (byteCnt != '1) byteCnt <= byteCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bridge_dp.sv
module bridge_dp
  import bridge_pkg::*;
#(
  parameter int NUM_BUS   = 2,
  parameter int MAX_LEN   = 2048,
  parameter int SUBSYS_ID = 1,
  parameter int FREQ_STD  = 100000,
  parameter int FREQ_FAST = 400000,
  parameter int FREQ_PLUS = 1000000
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strb,
  input  logic [7:0]  inData,
  output logic        cmdValid,
  output logic [7:0]  cmdOp,
  output logic [7:0]  cmdBus,
  output logic [6:0]  cmdAddr,
  output logic        cmdNoStop,
  output logic [15:0] cmdTxLen,
  output logic [15:0] cmdRxLen,
  output logic        rspValid,
  output logic [7:0]  rspOp,
  output logic [7:0]  rspStatus,
  output logic [31:0] rspFreq
);
  localparam int BUS_W = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1;

  logic [7:0] subB, opB, busB, f3, f4, f5, f6, f7, f8;
  logic [IDX_W-1:0] frameLen;
  logic [31:0] freqReg [NUM_BUS];

  // capture each byte by its position; position 0 wipes the previous frame
  always_ff @(posedge clk) begin
    if (!rstN) begin
      {subB, opB, busB, f3, f4, f5, f6, f7, f8} <= '0;
      frameLen <= '0;
    end else begin
      if (strb.load) begin
        if (strb.idx == '0) begin
          {opB, busB, f3, f4, f5, f6, f7, f8} <= '0;
          subB <= inData;
        end else begin
          case (strb.idx)
            IDX_W'(1): opB  <= inData;
            IDX_W'(2): busB <= inData;
            IDX_W'(3): f3   <= inData;
            IDX_W'(4): f4   <= inData;
            IDX_W'(5): f5   <= inData;
            IDX_W'(6): f6   <= inData;
            IDX_W'(7): f7   <= inData;
            IDX_W'(8): f8   <= inData;
            default: ;
          endcase
        end
      end
      if (strb.close) frameLen <= (strb.idx == '1) ? strb.idx : strb.idx + 1'b1;
    end
  end

  logic [15:0] txLen, rxLen;
  logic [31:0] freqIn;
  logic [BUS_W-1:0] busIdx;
  logic freqOk, isCmd;
  logic [7:0] status;

  assign txLen  = {f6, f5};
  assign rxLen  = {f8, f7};
  assign freqIn = {f6, f5, f4, f3};
  assign busIdx = busB[BUS_W-1:0];
  assign freqOk = (freqIn == 32'(FREQ_STD)) || (freqIn == 32'(FREQ_FAST)) ||
                  (freqIn == 32'(FREQ_PLUS));

  always_comb begin
    status = ST_OK;
    isCmd  = 1'b0;
    if (subB != 8'(SUBSYS_ID))           status = ST_INVAL;
    else if (frameLen < IDX_W'(2))       status = ST_SIZE;
    else if (opB > OP_GETF)              status = ST_INVAL;
    else if (frameLen < fixedLen(opB))   status = ST_SIZE;
    else if (busB >= 8'(NUM_BUS))        status = ST_NOBUS;
    else begin
      case (opB)
        OP_PROBE: if (f3[7]) status = ST_INVAL; else isCmd = 1'b1;
        OP_XFER: begin
          if (f3[7] || (f4[7:1] != '0))                            status = ST_INVAL;
          else if (txLen > 16'(MAX_LEN) || rxLen > 16'(MAX_LEN))   status = ST_SIZE;
          else                                                     isCmd = 1'b1;
        end
        OP_SCAN: isCmd = 1'b1;
        OP_SETF: if (!freqOk) status = ST_INVAL;
        default: ;
      endcase
    end
  end

  for (genvar b = 0; b < NUM_BUS; b++) begin : g_freq
    always_ff @(posedge clk) begin
      if (!rstN) freqReg[b] <= 32'(FREQ_STD);
      else if (strb.eval && opB == OP_SETF && status == ST_OK && busIdx == BUS_W'(b))
        freqReg[b] <= freqIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0; cmdValid <= 1'b0;
      rspOp <= '0; rspStatus <= '0; rspFreq <= '0;
      cmdOp <= '0; cmdBus <= '0; cmdAddr <= '0; cmdNoStop <= 1'b0;
      cmdTxLen <= '0; cmdRxLen <= '0;
    end else begin
      rspValid <= strb.eval;
      cmdValid <= strb.eval && isCmd;
      if (strb.eval) begin
        rspOp     <= opB;
        rspStatus <= status;
        rspFreq   <= (opB == OP_GETF && status == ST_OK) ? freqReg[busIdx] : '0;
        cmdOp     <= opB;
        cmdBus    <= busB;
        cmdAddr   <= (opB == OP_PROBE || opB == OP_XFER) ? f3[6:0] : '0;
        cmdNoStop <= (opB == OP_XFER) && f4[0];
        cmdTxLen  <= (opB == OP_XFER) ? txLen : '0;
        cmdRxLen  <= (opB == OP_XFER) ? rxLen : '0;
      end
    end
  end
endmodule

// File: rtl/bridge_cmd_decoder.sv
module bridge_cmd_decoder
  import bridge_pkg::*;
#(
  parameter int NUM_BUS   = 2,
  parameter int MAX_LEN   = 2048,
  parameter int SUBSYS_ID = 1,
  parameter int FREQ_STD  = 100000,
  parameter int FREQ_FAST = 400000,
  parameter int FREQ_PLUS = 1000000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [7:0]  inData,
  input  logic        inLast,
  output logic        cmdValid,
  output logic [7:0]  cmdOp,
  output logic [7:0]  cmdBus,
  output logic [6:0]  cmdAddr,
  output logic        cmdNoStop,
  output logic [15:0] cmdTxLen,
  output logic [15:0] cmdRxLen,
  output logic        rspValid,
  output logic [7:0]  rspSub,
  output logic [7:0]  rspOp,
  output logic [7:0]  rspStatus,
  output logic [31:0] rspFreq
);
  ctrlStrobe_t strb;

  assign rspSub = 8'(SUBSYS_ID);

  bridge_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast), .strb(strb)
  );

  bridge_dp #(
    .NUM_BUS(NUM_BUS), .MAX_LEN(MAX_LEN), .SUBSYS_ID(SUBSYS_ID),
    .FREQ_STD(FREQ_STD), .FREQ_FAST(FREQ_FAST), .FREQ_PLUS(FREQ_PLUS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inData(inData),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdBus(cmdBus), .cmdAddr(cmdAddr),
    .cmdNoStop(cmdNoStop), .cmdTxLen(cmdTxLen), .cmdRxLen(cmdRxLen),
    .rspValid(rspValid), .rspOp(rspOp), .rspStatus(rspStatus), .rspFreq(rspFreq)
  );
endmodule

// File: rtl/bridge_chk.sv
module bridge_chk #(
  parameter int MAX_LEN   = 2048,
  parameter int FREQ_STD  = 100000,
  parameter int FREQ_FAST = 400000,
  parameter int FREQ_PLUS = 1000000
) (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        inLast,
  input logic        cmdValid,
  input logic [7:0]  cmdOp,
  input logic [6:0]  cmdAddr,
  input logic        cmdNoStop,
  input logic [15:0] cmdTxLen,
  input logic [15:0] cmdRxLen,
  input logic        rspValid,
  input logic [7:0]  rspOp,
  input logic [7:0]  rspStatus,
  input logic [31:0] rspFreq
);
  p_resp_timing_r1: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(inValid && inLast, 2));

  p_status_code_r1: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspStatus == 8'd0 || rspStatus == 8'd2 || rspStatus == 8'd4 || rspStatus == 8'd7));

  p_reserved_op_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspOp > 8'h04) |-> rspStatus == 8'd2);

  p_len_limit_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 8'h01) |-> (cmdTxLen <= 16'(MAX_LEN) && cmdRxLen <= 16'(MAX_LEN)));

  p_cmd_on_ok_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (rspValid && rspStatus == 8'd0 && cmdOp <= 8'h02));

  p_scan_fields_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 8'h02) |-> (cmdAddr == '0 && !cmdNoStop && cmdTxLen == '0 && cmdRxLen == '0));

  p_freq_legal_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspOp == 8'h04 && rspStatus == 8'd0) |->
      (rspFreq == 32'(FREQ_STD) || rspFreq == 32'(FREQ_FAST) || rspFreq == 32'(FREQ_PLUS)));

  p_freq_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !(rspOp == 8'h04 && rspStatus == 8'd0)) |-> rspFreq == '0);
endmodule

bind bridge_cmd_decoder bridge_chk #(
  .MAX_LEN(MAX_LEN), .FREQ_STD(FREQ_STD), .FREQ_FAST(FREQ_FAST), .FREQ_PLUS(FREQ_PLUS)
) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast),
  .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr), .cmdNoStop(cmdNoStop),
  .cmdTxLen(cmdTxLen), .cmdRxLen(cmdRxLen), .rspValid(rspValid), .rspOp(rspOp),
  .rspStatus(rspStatus), .rspFreq(rspFreq)
);

// File: tb/bridge_cmd_decoder_tb_top.sv
module bridge_cmd_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inLast = 1'b0;
  logic [7:0] inData = '0;
  logic cmdValid, cmdNoStop, rspValid;
  logic [7:0] cmdOp, cmdBus, rspSub, rspOp, rspStatus;
  logic [6:0] cmdAddr;
  logic [15:0] cmdTxLen, cmdRxLen;
  logic [31:0] rspFreq;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bridge_cmd_decoder dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inLast(inLast),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdBus(cmdBus), .cmdAddr(cmdAddr),
    .cmdNoStop(cmdNoStop), .cmdTxLen(cmdTxLen), .cmdRxLen(cmdRxLen),
    .rspValid(rspValid), .rspSub(rspSub), .rspOp(rspOp), .rspStatus(rspStatus),
    .rspFreq(rspFreq)
  );

  typedef struct {
    bit v; int op; int st; longint fr;
    bit cmd; int cOp; int bus; int addr; bit ns; int tx; int rx;
    string tag;
  } exp_t;

  exp_t pipe1, pipe2;
  logic [7:0] frame[$];
  longint mFreq[2];

  function automatic exp_t modelFrame(ref logic [7:0] f[$]);
    exp_t e;
    int n = f.size();
    int need;
    int tx, rx;
    longint fr;
    e = '{v:1, op:0, st:0, fr:0, cmd:0, cOp:0, bus:0, addr:0, ns:0, tx:0, rx:0, tag:"R1"};
    if (n > 1) e.op = f[1];
    need = (e.op == 0) ? 4 : (e.op == 1) ? 9 : (e.op == 3) ? 7 : 3;
    if (f[0] != 8'h01) begin e.st = 2; e.tag = "R2"; end
    else if (n < 2) begin e.st = 7; e.tag = "R4"; end
    else if (e.op > 4) begin e.st = 2; e.tag = "R3"; end
    else if (n < need) begin e.st = 7; e.tag = "R4"; end
    else if (f[2] > 1) begin e.st = 4; e.tag = "R5"; end
    else begin
      e.bus = f[2];
      case (e.op)
        0: begin
          if (f[3] >= 8'h80) begin e.st = 2; e.tag = "R6"; end
          else begin e.cmd = 1; e.addr = f[3]; e.tag = "R7"; end
        end
        1: begin
          tx = f[5] + 256 * f[6];
          rx = f[7] + 256 * f[8];
          if (f[3] >= 8'h80 || f[4] > 1) begin e.st = 2; e.tag = "R6"; end
          else if (tx > 2048 || rx > 2048) begin e.st = 7; e.tag = "R6"; end
          else begin
            e.cmd = 1; e.addr = f[3]; e.ns = f[4][0]; e.tx = tx; e.rx = rx; e.tag = "R7";
          end
        end
        2: begin e.cmd = 1; e.tag = "R7"; end
        3: begin
          fr = f[3] + 256 * f[4] + 65536 * f[5] + 64'd16777216 * f[6];
          e.tag = "R8";
          if (fr == 100000 || fr == 400000 || fr == 1000000) mFreq[f[2]] = fr;
          else e.st = 2;
        end
        default: begin e.fr = mFreq[f[2]]; e.tag = "R9"; end
      endcase
    end
    e.cOp = e.op;
    return e;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      pipe1.v = 0; pipe2.v = 0; pipe1.cmd = 0; pipe2.cmd = 0;
      pipe1.tag = "R1"; pipe2.tag = "R1";
      frame.delete();
      mFreq[0] = 100000; mFreq[1] = 100000;
    end else begin
      pipe2 = pipe1;
      pipe1.v = 0; pipe1.cmd = 0; pipe1.tag = "R1";
      if (inValid) begin
        frame.push_back(inData);
        if (inLast) begin
          pipe1 = modelFrame(frame);
          frame.delete();
        end
      end
    end
  end

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      check(pipe2.tag, "rspValid", longint'(rspValid), longint'(pipe2.v));
      check(pipe2.tag, "cmdValid", longint'(cmdValid), longint'(pipe2.cmd));
      if (pipe2.v) begin
        check(pipe2.tag, "rspSub", rspSub, 1);
        check(pipe2.tag, "rspOp", rspOp, pipe2.op);
        check(pipe2.tag, "rspStatus", rspStatus, pipe2.st);
        check(pipe2.tag, "rspFreq", rspFreq, pipe2.fr);
      end
      if (pipe2.cmd) begin
        check(pipe2.tag, "cmdOp", cmdOp, pipe2.cOp);
        check(pipe2.tag, "cmdBus", cmdBus, pipe2.bus);
        check(pipe2.tag, "cmdAddr", cmdAddr, pipe2.addr);
        check(pipe2.tag, "cmdNoStop", longint'(cmdNoStop), longint'(pipe2.ns));
        check(pipe2.tag, "cmdTxLen", cmdTxLen, pipe2.tx);
        check(pipe2.tag, "cmdRxLen", cmdRxLen, pipe2.rx);
      end
    end
  end

  task automatic sendFrame(input logic [7:0] b[$], input int idle);
    for (int i = 0; i < b.size(); i++) begin
      @(negedge clk);
      inValid = 1'b1;
      inData  = b[i];
      inLast  = (i == b.size() - 1);
      if (i % 3 == 2 && idle > 1) begin
        @(negedge clk);
        inValid = 1'b0; inLast = 1'b0;
      end
    end
    if (idle > 0) begin
      @(negedge clk);
      inValid = 1'b0; inLast = 1'b0;
      repeat (idle - 1) @(negedge clk);
    end
  endtask

  task automatic finishRun();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [7:0] f[$];
    repeat (3) @(negedge clk);
    // reset state: outputs idle
    nChecks++;
    if (rspValid !== 1'b0 || cmdValid !== 1'b0) begin
      nFails++;
      $display("FAIL R1 reset: actual %0d/%0d expected 0/0", rspValid, cmdValid);
    end
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R10, R9: reset frequencies read back
    f = {8'h01, 8'h04, 8'h00}; sendFrame(f, 3);
    f = {8'h01, 8'h04, 8'h01}; sendFrame(f, 3);
    // R7: probe, and transfer with write data (R11) and no-stop
    f = {8'h01, 8'h00, 8'h00, 8'h48}; sendFrame(f, 2);
    f = {8'h01, 8'h01, 8'h01, 8'h50, 8'h01, 8'h02, 8'h00, 8'h01, 8'h00, 8'hAA, 8'h55}; sendFrame(f, 2);
    // R6: boundary 2048 ok, 2049 and read 0x0900 rejected
    f = {8'h01, 8'h01, 8'h00, 8'h10, 8'h00, 8'h00, 8'h08, 8'h00, 8'h08}; sendFrame(f, 2);
    f = {8'h01, 8'h01, 8'h00, 8'h10, 8'h00, 8'h01, 8'h08, 8'h00, 8'h00}; sendFrame(f, 2);
    f = {8'h01, 8'h01, 8'h00, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00, 8'h09}; sendFrame(f, 2);
    f = {8'h01, 8'h01, 8'h00, 8'h10, 8'h02, 8'h01, 8'h00, 8'h00, 8'h00}; sendFrame(f, 2);
    f = {8'h01, 8'h00, 8'h00, 8'h80}; sendFrame(f, 2);
    // R12: bad flags and oversize together -> invalid wins
    f = {8'h01, 8'h01, 8'h00, 8'h10, 8'h04, 8'hFF, 8'hFF, 8'h00, 8'h00}; sendFrame(f, 2);
    // R7, R11: scan with trailing bytes, R5 bad bus
    f = {8'h01, 8'h02, 8'h01, 8'h33, 8'h01, 8'h05}; sendFrame(f, 2);
    f = {8'h01, 8'h02, 8'h02}; sendFrame(f, 2);
    // R8: set, reject, read back
    f = {8'h01, 8'h03, 8'h01, 8'h80, 8'h1A, 8'h06, 8'h00}; sendFrame(f, 0);
    f = {8'h01, 8'h04, 8'h01}; sendFrame(f, 0);
    f = {8'h01, 8'h03, 8'h00, 8'h40, 8'hE2, 8'h01, 8'h00}; sendFrame(f, 0);
    f = {8'h01, 8'h04, 8'h00}; sendFrame(f, 2);
    f = {8'h01, 8'h03, 8'h00, 8'h40, 8'h42, 8'h0F, 8'h00}; sendFrame(f, 2);
    f = {8'h01, 8'h04, 8'h00}; sendFrame(f, 2);
    f = {8'h01, 8'h03, 8'h05, 8'h40, 8'h42, 8'h0F, 8'h00}; sendFrame(f, 2);
    // R3 reserved, R2 wrong subsystem
    f = {8'h01, 8'h05, 8'h00}; sendFrame(f, 2);
    f = {8'h01, 8'h7F}; sendFrame(f, 2);
    f = {8'h02, 8'h00, 8'h00, 8'h10}; sendFrame(f, 2);
    // R4 short frames, R12 bad bus in short frame
    f = {8'h01, 8'h00, 8'h00}; sendFrame(f, 2);
    f = {8'h01}; sendFrame(f, 2);
    f = {8'h01, 8'h01, 8'h00, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00}; sendFrame(f, 2);
    f = {8'h01, 8'h03, 8'h07, 8'hA0, 8'h86}; sendFrame(f, 2);
    f = {8'h01, 8'h04}; sendFrame(f, 4);
    finishRun();
  end
endmodule